// File: doc/BRIEF.md
# Static Branch and Return Next-PC Predictor

This block sits beside the fetch stage of a simple in-order pipeline and picks the address to fetch next. Each cycle it looks at the fetched instruction's PC, its class, the encoded branch target and the fall-through address. From these it produces a predicted next PC, a flag that says whether that PC leaves the sequential path, and a flag that says whether a return prediction came from a real stack entry. Conditional branches follow a fixed direction policy that the surrounding logic selects. Calls always go to their encoded target. Returns take their address from a small circular return-address stack.

Later in the pipeline, a resolution port compares the address the block predicted with the address the instruction actually produced, and raises a misprediction flag when they differ. The flag covers a return whose popped address was wrong because calls and returns did not pair up. With every prediction the block also outputs a checkpoint of the stack position as it stands after that instruction. The pipeline carries this checkpoint along with the instruction. On a misprediction the block puts the stack position back to the checkpoint that arrives with the resolution, and ignores the fetch presented in that cycle because it lies on the wrong path.

Top module: `next_pc_predictor`

## Requirements
- R1: After synchronous reset the return stack is empty, so a return predicts its fall-through address with `pred_from_stack` low, and `mispredict` is low while `res_valid` is low.
- R2: An instruction of class other (`fetch_kind` = 0) predicts its fall-through address with `pred_redirect` low, under every policy.
- R3: For a conditional branch (`fetch_kind` = 1), policy 0 predicts not taken (fall-through), policy 1 predicts taken (target), and the spare code 3 acts like policy 0.
- R4: Under policy 2, a conditional branch whose target is at or below its own PC predicts taken to the target, and one whose target is above its PC predicts the fall-through address.
- R5: A call (`fetch_kind` = 2) always predicts its encoded target with `pred_redirect` high, and pushes its fall-through address onto the stack.
- R6: A return (`fetch_kind` = 3) pops the most recently pushed address that is still held, predicts it with `pred_from_stack` and `pred_redirect` high, and nested calls come back in last-in, first-out order.
- R7: When more calls are pushed than the stack has entries (DEPTH), the oldest entry is overwritten and the newest DEPTH return addresses are still popped correctly.
- R8: A return fetched while the stack is empty predicts its fall-through address with `pred_from_stack` low and leaves the stack empty.
- R9: `mispredict` is high exactly when `res_valid` is high and `res_pred_pc` differs from `res_actual_pc`, including a return whose popped address was wrong.
- R10: In a cycle where `mispredict` is high, the stack position is restored from `res_ckpt` (the `pred_ckpt` that was output with the mispredicted instruction), the fetch presented in that same cycle does not change the stack, and entries below the restored position are popped correctly afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_policy | input | 2 | Conditional-branch policy: 0 never taken, 1 always taken, 2 backward taken/forward not taken, 3 treated as 0 |
| fetch_valid | input | 1 | A fetched instruction is presented this cycle |
| fetch_kind | input | 2 | Class: 0 other, 1 conditional branch, 2 call, 3 return |
| fetch_pc | input | AW | PC of the fetched instruction |
| fetch_target | input | AW | Encoded branch or call target |
| fetch_fallthru | input | AW | Address of the following instruction |
| pred_pc | output | AW | Predicted next PC |
| pred_redirect | output | 1 | Prediction leaves the sequential path |
| pred_from_stack | output | 1 | A return prediction came from a held stack entry |
| pred_ckpt | output | CKW | Stack position after this instruction, to be carried down the pipe |
| res_valid | input | 1 | An instruction resolves this cycle |
| res_pred_pc | input | AW | Next PC that was predicted for it |
| res_actual_pc | input | AW | Next PC it really produced |
| res_ckpt | input | CKW | Checkpoint that was output with it |
| mispredict | output | 1 | Resolution disagrees with the prediction |

## Verification
The bench builds the block with a 16-bit address and a four-entry stack. With only four entries, a run of five calls is enough to reach the wrap-around overwrite and then a drained, empty stack. With the short address, the direction cases (target below, equal to and above the PC) are easy to read. The checkpoint path is exercised by pushing wrong-path calls after a branch and then resolving that branch as mispredicted in the same cycle as another call, so the bench can see both the restore and the fact that the colliding fetch is ignored.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'd0,
        KIND_COND  = 2'd1,
        KIND_CALL  = 2'd2,
        KIND_RET   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        POL_NEVER    = 2'd0,
        POL_ALWAYS   = 2'd1,
        POL_BACKWARD = 2'd2,
        POL_SPARE    = 2'd3
    } policy_e;

    // Direction decision for a conditional branch under a static policy.
    function automatic logic policy_taken(policy_e pol, logic is_backward);
        case (pol)
            POL_ALWAYS:   return 1'b1;
            POL_BACKWARD: return is_backward;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bp_direction.sv
module bp_direction
    import bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  policy_e         policy,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   target,
    output logic            taken
);
    logic backward;

    // A target at or below the branch counts as a loop edge.
    assign backward = (target <= pc);
    assign taken    = policy_taken(policy, backward);

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int KW   = PW + CW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [AW-1:0]   push_addr,
    input  logic [AW-1:0]   empty_addr,
    input  logic            restore,
    input  logic [KW-1:0]   restore_ckpt,
    output logic [AW-1:0]   top_addr,
    output logic            top_valid,
    output logic [KW-1:0]   ckpt_after
);
    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, wr_ptr_n, top_ptr;
    logic [CW-1:0] fill, fill_n;
    logic          empty;

    assign empty     = (fill == '0);
    assign top_ptr   = wr_ptr - PW'(1);
    assign top_valid = !empty;
    assign top_addr  = empty ? empty_addr : slots[top_ptr];

    always_comb begin
        wr_ptr_n = wr_ptr;
        fill_n   = fill;
        if (push) begin
            wr_ptr_n = wr_ptr + PW'(1);
            if (fill != CW'(DEPTH))
                fill_n = fill + CW'(1);
        end else if (pop && !empty) begin
            wr_ptr_n = top_ptr;
            fill_n   = fill - CW'(1);
        end
    end

    assign ckpt_after = {fill_n, wr_ptr_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (restore) begin
            {fill, wr_ptr} <= restore_ckpt;
        end else begin
            wr_ptr <= wr_ptr_n;
            fill   <= fill_n;
        end
    end

    // Storage needs no reset: an empty stack never reads it.
    always_ff @(posedge clk) begin
        if (!rst && !restore && push)
            slots[wr_ptr] <= push_addr;
    end

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
    parameter int AW = 32
) (
    input  logic            res_valid,
    input  logic [AW-1:0]   res_pred_pc,
    input  logic [AW-1:0]   res_actual_pc,
    output logic            wrong
);
    assign wrong = res_valid && (res_pred_pc != res_actual_pc);
endmodule

// File: rtl/next_pc_predictor.sv
module next_pc_predictor
    import bp_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CKW  = $clog2(DEPTH) + $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      cfg_policy,
    input  logic            fetch_valid,
    input  logic [1:0]      fetch_kind,
    input  logic [AW-1:0]   fetch_pc,
    input  logic [AW-1:0]   fetch_target,
    input  logic [AW-1:0]   fetch_fallthru,
    output logic [AW-1:0]   pred_pc,
    output logic            pred_redirect,
    output logic            pred_from_stack,
    output logic [CKW-1:0]  pred_ckpt,
    input  logic            res_valid,
    input  logic [AW-1:0]   res_pred_pc,
    input  logic [AW-1:0]   res_actual_pc,
    input  logic [CKW-1:0]  res_ckpt,
    output logic            mispredict
);
    kind_e         kind;
    policy_e       policy;
    logic          cond_taken;
    logic          flush;
    logic          accept;
    logic          do_push, do_pop;
    logic [AW-1:0] ras_addr;
    logic          ras_valid;

    assign kind   = kind_e'(fetch_kind);
    assign policy = policy_e'(cfg_policy);

    bp_direction #(.AW(AW)) u_dir (
        .policy (policy),
        .pc     (fetch_pc),
        .target (fetch_target),
        .taken  (cond_taken)
    );

    bp_resolve #(.AW(AW)) u_res (
        .res_valid     (res_valid),
        .res_pred_pc   (res_pred_pc),
        .res_actual_pc (res_actual_pc),
        .wrong         (mispredict)
    );

    // A mispredict squashes the fetch presented in the same cycle.
    assign flush   = mispredict;
    assign accept  = fetch_valid && !flush;
    assign do_push = accept && (kind == KIND_CALL);
    assign do_pop  = accept && (kind == KIND_RET);

    bp_ras #(.AW(AW), .DEPTH(DEPTH)) u_ras (
        .clk          (clk),
        .rst          (rst),
        .push         (do_push),
        .pop          (do_pop),
        .push_addr    (fetch_fallthru),
        .empty_addr   (fetch_fallthru),
        .restore      (flush),
        .restore_ckpt (res_ckpt),
        .top_addr     (ras_addr),
        .top_valid    (ras_valid),
        .ckpt_after   (pred_ckpt)
    );

    always_comb begin
        pred_pc         = fetch_fallthru;
        pred_redirect   = 1'b0;
        pred_from_stack = 1'b0;
        case (kind)
            KIND_COND: begin
                pred_redirect = cond_taken;
                pred_pc       = cond_taken ? fetch_target : fetch_fallthru;
            end
            KIND_CALL: begin
                pred_redirect = 1'b1;
                pred_pc       = fetch_target;
            end
            KIND_RET: begin
                pred_from_stack = ras_valid;
                pred_redirect   = ras_valid;
                pred_pc         = ras_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/next_pc_predictor_checker.sv
module next_pc_predictor_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_valid,
    input logic [1:0]    fetch_kind,
    input logic [AW-1:0] fetch_target,
    input logic [AW-1:0] fetch_fallthru,
    input logic [AW-1:0] pred_pc,
    input logic          pred_redirect,
    input logic          pred_from_stack,
    input logic          res_valid,
    input logic          mispredict
);
    logic live_call, live_ret;
    assign live_call = fetch_valid && fetch_kind == 2'd2 && !mispredict;
    assign live_ret  = fetch_valid && fetch_kind == 2'd3 && !mispredict;

    AST_OTHER_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'd0 |-> pred_pc == fetch_fallthru && !pred_redirect); // R2

    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'd2 |-> pred_pc == fetch_target && pred_redirect); // R5

    AST_CALL_THEN_RET: assert property (@(posedge clk) disable iff (rst)
        live_ret && $past(live_call) && $past(!rst)
        |-> pred_pc == $past(fetch_fallthru) && pred_from_stack); // R6

    AST_EMPTY_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'd3 && !pred_from_stack |-> pred_pc == fetch_fallthru); // R8

    AST_STACK_FLAG_RET_ONLY: assert property (@(posedge clk) disable iff (rst)
        fetch_kind != 2'd3 |-> !pred_from_stack); // R6

    AST_QUIET_RESOLVE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !mispredict); // R9

endmodule

bind next_pc_predictor next_pc_predictor_checker #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .fetch_valid     (fetch_valid),
    .fetch_kind      (fetch_kind),
    .fetch_target    (fetch_target),
    .fetch_fallthru  (fetch_fallthru),
    .pred_pc         (pred_pc),
    .pred_redirect   (pred_redirect),
    .pred_from_stack (pred_from_stack),
    .res_valid       (res_valid),
    .mispredict      (mispredict)
);

// File: tb/next_pc_predictor_test.sv
`timescale 1ns/1ps
module next_pc_predictor_test;
    localparam int AW    = 16;
    localparam int DEPTH = 4;
    localparam int CKW   = $clog2(DEPTH) + $clog2(DEPTH + 1);

    logic           clk = 1'b0;
    logic           rst;
    logic [1:0]     cfg_policy;
    logic           fetch_valid;
    logic [1:0]     fetch_kind;
    logic [AW-1:0]  fetch_pc, fetch_target, fetch_fallthru;
    logic [AW-1:0]  pred_pc;
    logic           pred_redirect, pred_from_stack;
    logic [CKW-1:0] pred_ckpt;
    logic           res_valid;
    logic [AW-1:0]  res_pred_pc, res_actual_pc;
    logic [CKW-1:0] res_ckpt;
    logic           mispredict;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    next_pc_predictor #(.AW(AW), .DEPTH(DEPTH)) uut (.*);

    typedef struct packed {
        logic [1:0]    pol;
        logic [1:0]    kind;
        logic [AW-1:0] pc;
        logic [AW-1:0] tgt;
        logic [AW-1:0] fall;
        logic [AW-1:0] exp_pc;
        logic          exp_redir;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 16'h0100, 16'h0080, 16'h0104, 16'h0104, 1'b0},
        '{2'd1, 2'd1, 16'h0100, 16'h0080, 16'h0104, 16'h0080, 1'b1},
        '{2'd1, 2'd1, 16'h0100, 16'h0200, 16'h0104, 16'h0200, 1'b1},
        '{2'd2, 2'd1, 16'h0100, 16'h0080, 16'h0104, 16'h0080, 1'b1},
        '{2'd2, 2'd1, 16'h0100, 16'h0200, 16'h0104, 16'h0104, 1'b0},
        '{2'd2, 2'd1, 16'h0100, 16'h0100, 16'h0104, 16'h0100, 1'b1},
        '{2'd3, 2'd1, 16'h0100, 16'h0080, 16'h0104, 16'h0104, 1'b0},
        '{2'd2, 2'd0, 16'h0100, 16'h0080, 16'h0104, 16'h0104, 1'b0},
        '{2'd1, 2'd0, 16'h0300, 16'h0200, 16'h0304, 16'h0304, 1'b0},
        '{2'd0, 2'd1, 16'h0300, 16'h0400, 16'h0304, 16'h0304, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a fetch in the low phase, then let outputs settle.
    task automatic cyc(logic [1:0] k, logic [AW-1:0] pc, logic [AW-1:0] tgt,
                       logic [AW-1:0] fall);
        @(negedge clk);
        res_valid      = 1'b0;
        fetch_valid    = 1'b1;
        fetch_kind     = k;
        fetch_pc       = pc;
        fetch_target   = tgt;
        fetch_fallthru = fall;
        #1;
    endtask

    task automatic resolve(logic [AW-1:0] p, logic [AW-1:0] a, logic [CKW-1:0] ck);
        res_valid     = 1'b1;
        res_pred_pc   = p;
        res_actual_pc = a;
        res_ckpt      = ck;
        #1;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [CKW-1:0] ck_empty, ck_branch;
        rst = 1'b1; cfg_policy = 2'd2; fetch_valid = 1'b0; fetch_kind = 2'd0;
        fetch_pc = '0; fetch_target = '0; fetch_fallthru = '0;
        res_valid = 1'b0; res_pred_pc = '0; res_actual_pc = '0; res_ckpt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset leaves an empty stack
        cyc(2'd3, 16'h0900, 16'h0000, 16'h0904);
        check("R1 pc", pred_pc, 16'h0904);
        check("R1 stack flag", pred_from_stack, 1'b0);
        check("R1 mispredict idle", mispredict, 1'b0);

        // Table walk: R2 other class, R3 fixed policies, R4 backward rule
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (VECS[i].kind == 2'd0) ? "R2" : (VECS[i].pol == 2'd2) ? "R4" : "R3";
            cfg_policy = VECS[i].pol;
            cyc(VECS[i].kind, VECS[i].pc, VECS[i].tgt, VECS[i].fall);
            check($sformatf("%s vec%0d pc", tag, i), pred_pc, VECS[i].exp_pc);
            check($sformatf("%s vec%0d redirect", tag, i), pred_redirect, VECS[i].exp_redir);
        end
        cfg_policy = 2'd2;

        // R5 calls, R6 nested returns
        cyc(2'd2, 16'h1000, 16'h2000, 16'h1004);
        check("R5 call pc", pred_pc, 16'h2000);
        check("R5 call redirect", pred_redirect, 1'b1);
        cyc(2'd2, 16'h2010, 16'h3000, 16'h2014);
        cyc(2'd3, 16'h3020, 16'h0000, 16'h3024);
        check("R6 inner ret", pred_pc, 16'h2014);
        check("R6 inner flag", pred_from_stack, 1'b1);
        cyc(2'd3, 16'h2020, 16'h0000, 16'h2024);
        check("R6 outer ret", pred_pc, 16'h1004);
        // R8 empty pop
        cyc(2'd3, 16'h5000, 16'h0000, 16'h5004);
        check("R8 empty pc", pred_pc, 16'h5004);
        check("R8 empty flag", pred_from_stack, 1'b0);
        cyc(2'd3, 16'h5100, 16'h0000, 16'h5104);
        check("R8 still empty", pred_from_stack, 1'b0);

        // R7 overflow: five calls into four entries
        for (int i = 1; i <= 5; i++)
            cyc(2'd2, AW'(i * 256), 16'h7000, AW'(i * 256 + 4));
        for (int i = 5; i >= 2; i--) begin
            cyc(2'd3, 16'h7010, 16'h0000, 16'h7014);
            check($sformatf("R7 pop %0d", i), pred_pc, AW'(i * 256 + 4));
        end
        cyc(2'd3, 16'h7020, 16'h0000, 16'h7024);
        check("R7 oldest dropped", pred_from_stack, 1'b0);

        // R9 resolution compare
        cyc(2'd0, 16'h0A00, 16'h0000, 16'h0A04);
        ck_empty = pred_ckpt;
        fetch_valid = 1'b0;
        resolve(16'h1234, 16'h1234, ck_empty);
        check("R9 match", mispredict, 1'b0);
        resolve(16'h1234, 16'h1238, ck_empty);
        check("R9 differ", mispredict, 1'b1);
        // R9 unmatched return: ret popped a stale address
        cyc(2'd2, 16'h0B00, 16'h0C00, 16'h0B04);
        cyc(2'd3, 16'h0C10, 16'h0000, 16'h0C14);
        check("R9 ret pred", pred_pc, 16'h0B04);
        ck_branch = pred_ckpt;
        fetch_valid = 1'b0;
        resolve(16'h0B04, 16'h0E00, ck_branch);
        check("R9 bad ret flagged", mispredict, 1'b1);

        // R10 checkpoint restore with a colliding fetch
        cyc(2'd2, 16'h1000, 16'h1100, 16'h1004);
        cyc(2'd1, 16'h1100, 16'h1200, 16'h1104);
        ck_branch = pred_ckpt;
        cyc(2'd2, 16'h4000, 16'h4400, 16'h4004);
        cyc(2'd2, 16'h5000, 16'h5500, 16'h5004);
        cyc(2'd2, 16'h6000, 16'h6600, 16'h6004);
        resolve(16'h1104, 16'h1200, ck_branch);
        check("R10 flush raised", mispredict, 1'b1);
        cyc(2'd3, 16'h1200, 16'h0000, 16'h1204);
        check("R10 restored top", pred_pc, 16'h1004);
        check("R10 restored flag", pred_from_stack, 1'b1);
        cyc(2'd3, 16'h1300, 16'h0000, 16'h1304);
        check("R10 below empty", pred_from_stack, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule